// File: doc/BRIEF.md
# Host Command Wrapper for a Processor Datapath

This block is the control shell that sits between a host message channel and a processor datapath treated as a black box. Commands arrive from the head of an input FIFO. Responses leave through an output FIFO. The wrapper loads instruction memory words and register file entries into the datapath, pulses the datapath reset, and starts and stops runs. While the core runs, it counts cycles, retired instructions and branch mispredictions. It also keeps a shadow copy of every register value written at the writeback stage, so the host can read the results back once the run has ended.

The exchange is strictly stop-and-wait. A command is taken from the FIFO only when no response is pending. Every command produces exactly one response. A run command is answered only when the run ends, either because the datapath raises halt or because a stop command arrives. While a run is in progress, stop is the only command the wrapper will dequeue.

Top module: `hcw_wrapper`

## Requirements
- R1: Each command has three fields: a 4-bit opcode, a 10-bit address and an XLEN-bit data word. `cmd_ready` is low whenever a response is pending or a run is outstanding, except for a stop command during a run. A response stays valid, with its code, opcode echo and data unchanged, until `rsp_ready` accepts it.
- R2: Opcode 0 (load instruction word) produces one single-cycle `imem_we` pulse in the cycle after acceptance. The pulse carries the low IMEM_AW address bits and the data word. The response is an acknowledge: code 0, opcode echoed, data 0.
- R3: Opcode 1 (load register) produces one single-cycle `rf_we` pulse to register index cmd_addr[RF_AW-1:0] with the data word. It also updates the shadow copy and is answered with an acknowledge.
- R4: Register 0 always reads as zero. A load to index 0 is acknowledged but raises no `rf_we`. A writeback to index 0 leaves the shadow copy unchanged.
- R5: Opcode 2 (reset) produces a single-cycle `dp_rst` pulse while the core is not running. That pulse clears all three counters and every shadow register. The command is answered with an acknowledge.
- R6: Opcode 3 (run) raises `dp_run` in the cycle after acceptance, with no immediate response. No load pulses occur while it is high. Commands other than stop stay in the input FIFO until the run ends.
- R7: A halt during a run drops `dp_run` and sends code 2 (done by halt). A stop during a run drops `dp_run` and sends code 3 (done by stop), followed by an acknowledge for the stop. Both done responses echo opcode 3. If halt and a stop coincide, halt wins and the stop is later handled as an idle stop. A stop while idle is simply acknowledged.
- R8: A writeback (`wb_valid`) is copied into the shadow register file only while `dp_run` is high. A writeback at any other time is ignored.
- R9: The cycle, retire and mispredict counters advance only in cycles where `dp_run` is high. They wrap modulo 2^CNT_W.
- R10: Opcode 5 (read) answers with code 1. Address bits [9:8] select the data returned: 0 returns shadow register cmd_addr[RF_AW-1:0], 1 the cycle count, 2 the retire count, 3 the mispredict count. Counter values are zero-extended.
- R11: Opcodes 6 to 15 are answered with code 4 and touch no datapath port, counter or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Input FIFO holds a command |
| cmd_ready | output | 1 | Dequeue the head command |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | ADDR_W | Command address field |
| cmd_data | input | XLEN | Command data field |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Output FIFO takes the response |
| rsp_code | output | 3 | Response kind |
| rsp_op | output | 4 | Opcode being answered |
| rsp_data | output | XLEN | Response payload |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | IMEM_AW | Instruction memory word address |
| imem_wdata | output | XLEN | Instruction word |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | RF_AW | Register index |
| rf_wdata | output | XLEN | Register value |
| dp_rst | output | 1 | Datapath reset pulse |
| dp_run | output | 1 | Datapath run enable |
| wb_valid | input | 1 | Writeback stage writes a register |
| wb_addr | input | RF_AW | Writeback register index |
| wb_data | input | XLEN | Writeback value |
| dp_retire | input | 1 | One instruction retired |
| dp_mispredict | input | 1 | One branch mispredicted |
| dp_halt | input | 1 | Datapath requests end of run |

## Verification
The bench builds the wrapper with IMEM_AW=6, RF_AW=3 and CNT_W=8. The narrow instruction address lets a high address show truncation at the port. Eight registers let the whole shadow file be loaded and read back. An 8-bit counter wraps within a single run of about three hundred cycles, so the modulo rule is checked on real traffic. The same configuration also covers the stop-and-wait ordering: a load held back during a run, backpressure on a done response, and halt and stop arriving in the same cycle.

// File: rtl/hcw_pkg.sv
package hcw_pkg;
  localparam int OP_W   = 4;
  localparam int CODE_W = 3;

  localparam logic [OP_W-1:0] OP_LDI  = 4'd0;
  localparam logic [OP_W-1:0] OP_LDR  = 4'd1;
  localparam logic [OP_W-1:0] OP_RST  = 4'd2;
  localparam logic [OP_W-1:0] OP_RUN  = 4'd3;
  localparam logic [OP_W-1:0] OP_STOP = 4'd4;
  localparam logic [OP_W-1:0] OP_RD   = 4'd5;

  localparam logic [CODE_W-1:0] RC_ACK       = 3'd0;
  localparam logic [CODE_W-1:0] RC_DATA      = 3'd1;
  localparam logic [CODE_W-1:0] RC_DONE_HALT = 3'd2;
  localparam logic [CODE_W-1:0] RC_DONE_STOP = 3'd3;
  localparam logic [CODE_W-1:0] RC_BAD       = 3'd4;

  localparam logic [1:0] SEL_REG = 2'd0;
  localparam logic [1:0] SEL_CYC = 2'd1;
  localparam logic [1:0] SEL_RET = 2'd2;
  localparam logic [1:0] SEL_MIS = 2'd3;

  localparam int N_CNT = 3;
  localparam int CNT_CYC = 0;
  localparam int CNT_RET = 1;
  localparam int CNT_MIS = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RSP} hcw_state_e;
endpackage

// File: rtl/hcw_perf.sv
module hcw_perf #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             active,
  input  logic             retire,
  input  logic             mispredict,
  output logic [CNT_W-1:0] cyc_cnt,
  output logic [CNT_W-1:0] ret_cnt,
  output logic [CNT_W-1:0] mis_cnt
);
  import hcw_pkg::*;

  logic [N_CNT-1:0] ev;
  logic [CNT_W-1:0] cnt_q [N_CNT];

  always_comb begin
    ev = '0;
    ev[CNT_CYC] = 1'b1;
    ev[CNT_RET] = retire;
    ev[CNT_MIS] = mispredict;
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || clr)
        cnt_q[g] <= '0;
      else if (active && ev[g])
        cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign cyc_cnt = cnt_q[CNT_CYC];
  assign ret_cnt = cnt_q[CNT_RET];
  assign mis_cnt = cnt_q[CNT_MIS];
endmodule

// File: rtl/hcw_shadow_rf.sv
module hcw_shadow_rf #(
  parameter int XLEN  = 32,
  parameter int RF_AW = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld_we,
  input  logic [RF_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  input  logic             wb_we,
  input  logic [RF_AW-1:0] wb_addr,
  input  logic [XLEN-1:0]  wb_data,
  input  logic [RF_AW-1:0] rd_addr,
  output logic [XLEN-1:0]  rd_data
);
  localparam int NREG = 1 << RF_AW;

  logic [XLEN-1:0] regs [NREG];

  // Entry 0 is cleared with the others and never written afterwards.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (ld_we && ld_addr != '0) regs[ld_addr] <= ld_data;
      if (wb_we && wb_addr != '0) regs[wb_addr] <= wb_data;
    end
  end

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/hcw_ctrl.sv
module hcw_ctrl #(
  parameter int XLEN    = 32,
  parameter int ADDR_W  = 10,
  parameter int IMEM_AW = 10,
  parameter int RF_AW   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [3:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [XLEN-1:0]    cmd_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [2:0]         rsp_code,
  output logic [3:0]         rsp_op,
  output logic [XLEN-1:0]    rsp_data,
  input  logic [XLEN-1:0]    rd_data,
  input  logic               dp_halt,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [XLEN-1:0]    imem_wdata,
  output logic               rf_we,
  output logic [RF_AW-1:0]   rf_addr,
  output logic [XLEN-1:0]    rf_wdata,
  output logic               dp_rst,
  output logic               dp_run
);
  import hcw_pkg::*;

  hcw_state_e st;
  logic       stop_pend;
  logic       is_stop;

  assign is_stop = (cmd_op == OP_STOP);

  always_comb begin
    unique case (st)
      ST_IDLE: cmd_ready = 1'b1;
      ST_RUN:  cmd_ready = !dp_halt && is_stop;
      default: cmd_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      stop_pend  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_code   <= RC_ACK;
      rsp_op     <= '0;
      rsp_data   <= '0;
      imem_we    <= 1'b0;
      imem_addr  <= '0;
      imem_wdata <= '0;
      rf_we      <= 1'b0;
      rf_addr    <= '0;
      rf_wdata   <= '0;
      dp_rst     <= 1'b0;
      dp_run     <= 1'b0;
    end else begin
      imem_we <= 1'b0;
      rf_we   <= 1'b0;
      dp_rst  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            rsp_op   <= cmd_op;
            rsp_code <= RC_ACK;
            rsp_data <= '0;
            rsp_valid <= 1'b1;
            st       <= ST_RSP;
            case (cmd_op)
              OP_LDI: begin
                imem_we    <= 1'b1;
                imem_addr  <= cmd_addr[IMEM_AW-1:0];
                imem_wdata <= cmd_data;
              end
              OP_LDR: begin
                rf_we    <= (cmd_addr[RF_AW-1:0] != '0);
                rf_addr  <= cmd_addr[RF_AW-1:0];
                rf_wdata <= cmd_data;
              end
              OP_RST:  dp_rst <= 1'b1;
              OP_RUN: begin
                dp_run    <= 1'b1;
                rsp_valid <= 1'b0;
                st        <= ST_RUN;
              end
              OP_STOP: ;
              OP_RD: begin
                rsp_code <= RC_DATA;
                rsp_data <= rd_data;
              end
              default: rsp_code <= RC_BAD;
            endcase
          end
        end
        ST_RUN: begin
          if (dp_halt) begin
            dp_run    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_code  <= RC_DONE_HALT;
            rsp_op    <= OP_RUN;
            rsp_data  <= '0;
            st        <= ST_RSP;
          end else if (cmd_valid && is_stop) begin
            dp_run    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_code  <= RC_DONE_STOP;
            rsp_op    <= OP_RUN;
            rsp_data  <= '0;
            stop_pend <= 1'b1;
            st        <= ST_RSP;
          end
        end
        default: begin
          if (rsp_ready) begin
            if (stop_pend) begin
              stop_pend <= 1'b0;
              rsp_code  <= RC_ACK;
              rsp_op    <= OP_STOP;
              rsp_data  <= '0;
            end else begin
              rsp_valid <= 1'b0;
              st        <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hcw_wrapper.sv
module hcw_wrapper #(
  parameter int XLEN    = 32,
  parameter int ADDR_W  = 10,
  parameter int IMEM_AW = 10,
  parameter int RF_AW   = 5,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [3:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [XLEN-1:0]    cmd_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [2:0]         rsp_code,
  output logic [3:0]         rsp_op,
  output logic [XLEN-1:0]    rsp_data,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [XLEN-1:0]    imem_wdata,
  output logic               rf_we,
  output logic [RF_AW-1:0]   rf_addr,
  output logic [XLEN-1:0]    rf_wdata,
  output logic               dp_rst,
  output logic               dp_run,
  input  logic               wb_valid,
  input  logic [RF_AW-1:0]   wb_addr,
  input  logic [XLEN-1:0]    wb_data,
  input  logic               dp_retire,
  input  logic               dp_mispredict,
  input  logic               dp_halt
);
  import hcw_pkg::*;

  localparam int SEL_HI = ADDR_W - 1;

  logic [CNT_W-1:0] cyc_cnt, ret_cnt, mis_cnt;
  logic [XLEN-1:0]  shadow_rd;
  logic [XLEN-1:0]  rd_mux;
  logic [1:0]       rd_sel;

  hcw_ctrl #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .IMEM_AW(IMEM_AW), .RF_AW(RF_AW)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_code(rsp_code), .rsp_op(rsp_op), .rsp_data(rsp_data),
    .rd_data(rd_mux), .dp_halt(dp_halt),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .dp_rst(dp_rst), .dp_run(dp_run)
  );

  hcw_shadow_rf #(.XLEN(XLEN), .RF_AW(RF_AW)) u_shadow (
    .clk(clk), .rst(rst), .clr(dp_rst),
    .ld_we(rf_we), .ld_addr(rf_addr), .ld_data(rf_wdata),
    .wb_we(wb_valid && dp_run), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_addr(cmd_addr[RF_AW-1:0]), .rd_data(shadow_rd)
  );

  hcw_perf #(.CNT_W(CNT_W)) u_perf (
    .clk(clk), .rst(rst), .clr(dp_rst), .active(dp_run),
    .retire(dp_retire), .mispredict(dp_mispredict),
    .cyc_cnt(cyc_cnt), .ret_cnt(ret_cnt), .mis_cnt(mis_cnt)
  );

  assign rd_sel = cmd_addr[SEL_HI -: 2];

  always_comb begin
    unique case (rd_sel)
      SEL_REG: rd_mux = shadow_rd;
      SEL_CYC: rd_mux = XLEN'(cyc_cnt);
      SEL_RET: rd_mux = XLEN'(ret_cnt);
      default: rd_mux = XLEN'(mis_cnt);
    endcase
  end
endmodule

// File: rtl/hcw_checker.sv
module hcw_checker #(
  parameter int XLEN  = 32,
  parameter int RF_AW = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_ready,
  input logic [3:0]       cmd_op,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [2:0]       rsp_code,
  input logic [3:0]       rsp_op,
  input logic [XLEN-1:0]  rsp_data,
  input logic             imem_we,
  input logic             rf_we,
  input logic [RF_AW-1:0] rf_addr,
  input logic             dp_rst,
  input logic             dp_run,
  input logic             dp_halt
);
  import hcw_pkg::*;

  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_op) && $stable(rsp_data));

  p_no_deq_pending_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cmd_ready);

  p_imem_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    imem_we |=> !imem_we);

  p_rf_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  p_r0_guard_r4: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_addr != '0);

  p_rst_idle_r5: assert property (@(posedge clk) disable iff (rst)
    dp_rst |-> !dp_run);

  p_run_only_stop_r6: assert property (@(posedge clk) disable iff (rst)
    dp_run && cmd_ready |-> cmd_op == OP_STOP);

  p_run_no_load_r6: assert property (@(posedge clk) disable iff (rst)
    dp_run |-> !imem_we && !rf_we);

  p_halt_done_r7: assert property (@(posedge clk) disable iff (rst)
    dp_run && dp_halt |=> !dp_run && rsp_valid && rsp_code == RC_DONE_HALT);
endmodule

bind hcw_wrapper hcw_checker #(.XLEN(XLEN), .RF_AW(RF_AW)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
  .rsp_op(rsp_op), .rsp_data(rsp_data), .imem_we(imem_we), .rf_we(rf_we),
  .rf_addr(rf_addr), .dp_rst(dp_rst), .dp_run(dp_run), .dp_halt(dp_halt)
);

// File: tb/hcw_wrapper_tb.sv
module hcw_wrapper_tb;
  import hcw_pkg::*;

  localparam int XLEN = 32, ADDR_W = 10, IMEM_AW = 6, RF_AW = 3, CNT_W = 8;
  localparam int NREG = 1 << RF_AW;
  localparam int CMOD = 1 << CNT_W;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_ready;
  logic [3:0] cmd_op = 0;
  logic [ADDR_W-1:0] cmd_addr = 0;
  logic [XLEN-1:0] cmd_data = 0;
  logic rsp_valid, rsp_ready = 1;
  logic [2:0] rsp_code;
  logic [3:0] rsp_op;
  logic [XLEN-1:0] rsp_data;
  logic imem_we, rf_we, dp_rst, dp_run;
  logic [IMEM_AW-1:0] imem_addr;
  logic [XLEN-1:0] imem_wdata, rf_wdata;
  logic [RF_AW-1:0] rf_addr;
  logic wb_valid = 0, dp_retire = 0, dp_mispredict = 0, dp_halt = 0;
  logic [RF_AW-1:0] wb_addr = 0;
  logic [XLEN-1:0] wb_data = 0;

  always #5 clk = ~clk;

  hcw_wrapper #(.XLEN(XLEN), .ADDR_W(ADDR_W), .IMEM_AW(IMEM_AW), .RF_AW(RF_AW), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_op(rsp_op), .rsp_data(rsp_data), .imem_we(imem_we),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .dp_rst(dp_rst), .dp_run(dp_run),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .dp_retire(dp_retire), .dp_mispredict(dp_mispredict), .dp_halt(dp_halt)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard of expected responses
  typedef struct {
    logic [2:0] code;
    logic [3:0] op;
    logic [XLEN-1:0] data;
    string req;
  } exp_t;
  exp_t sb_q[$];

  always @(negedge clk) begin
    #2;
    if (!rst && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) begin
        chk("R1 unexpected response", {rsp_code, rsp_op}, '1);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " code"}, XLEN'(rsp_code), XLEN'(e.code));
        chk({e.req, " op"}, XLEN'(rsp_op), XLEN'(e.op));
        chk({e.req, " data"}, rsp_data, e.data);
      end
    end
  end

  // Port pulse monitors
  int imem_cnt = 0, rf_cnt = 0, rstp_cnt = 0;
  logic [IMEM_AW-1:0] last_imem_addr;
  logic [XLEN-1:0] last_imem_data;
  logic [RF_AW-1:0] last_rf_addr;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (imem_we) begin imem_cnt++; last_imem_addr = imem_addr; last_imem_data = imem_wdata; end
      if (rf_we) begin rf_cnt++; last_rf_addr = rf_addr; end
      if (dp_rst) rstp_cnt++;
    end
  end

  // Counter model from the requirements (R9)
  int m_cyc = 0, m_ret = 0, m_mis = 0;
  always @(posedge clk) begin
    if (rst || dp_rst) begin
      m_cyc = 0; m_ret = 0; m_mis = 0;
    end else if (dp_run) begin
      m_cyc++;
      if (dp_retire) m_ret++;
      if (dp_mispredict) m_mis++;
    end
  end

  logic [XLEN-1:0] exp_rf [NREG];

  task automatic send(input logic [3:0] op, input logic [ADDR_W-1:0] addr,
                      input logic [XLEN-1:0] data, input logic [2:0] ecode,
                      input logic [3:0] eop, input logic [XLEN-1:0] edata, input string req);
    exp_t e;
    e.code = ecode; e.op = eop; e.data = edata; e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = addr; cmd_data = data;
    forever begin
      #1;
      if (cmd_ready) begin
        @(posedge clk);
        #1 cmd_valid = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_reg(input int idx, input logic [XLEN-1:0] exp, input string req);
    send(OP_RD, ADDR_W'(idx), '0, RC_DATA, OP_RD, exp, req);
  endtask

  task automatic rd_stats(input string req);
    send(OP_RD, 10'h100, '0, RC_DATA, OP_RD, XLEN'(m_cyc % CMOD), {req, " cycles"});
    send(OP_RD, 10'h200, '0, RC_DATA, OP_RD, XLEN'(m_ret % CMOD), {req, " retired"});
    send(OP_RD, 10'h300, '0, RC_DATA, OP_RD, XLEN'(m_mis % CMOD), {req, " mispredict"});
    drain();
  endtask

  bit finished = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_rf[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R1/R6 reset state
    chk("R1 reset cmd_ready", XLEN'(cmd_ready), 1);
    chk("R1 reset rsp_valid", XLEN'(rsp_valid), 0);
    chk("R6 reset dp_run", XLEN'(dp_run), 0);

    // R9: events while idle are ignored
    @(negedge clk); dp_retire = 1; dp_mispredict = 1;
    repeat (3) @(negedge clk); dp_retire = 0; dp_mispredict = 0;

    // R2: instruction load with address truncation
    send(OP_LDI, 10'h3C5, 32'hA5A5_0001, RC_ACK, OP_LDI, '0, "R2 ack");
    drain();
    chk("R2 pulse count", imem_cnt, 1);
    chk("R2 addr", XLEN'(last_imem_addr), 32'h05);
    chk("R2 data", last_imem_data, 32'hA5A5_0001);
    send(OP_LDI, 10'h000, 32'h0000_00FF, RC_ACK, OP_LDI, '0, "R2 ack2");
    drain();
    chk("R2 pulse count2", imem_cnt, 2);
    chk("R2 addr2", XLEN'(last_imem_addr), 0);

    // R3: register loads and read-back (R10)
    for (int i = 1; i < NREG; i++) begin
      exp_rf[i] = 32'h1000_0000 + i * 32'h0101;
      send(OP_LDR, ADDR_W'(i), exp_rf[i], RC_ACK, OP_LDR, '0, "R3 ack");
    end
    drain();
    chk("R3 pulse count", rf_cnt, NREG - 1);
    chk("R3 last addr", XLEN'(last_rf_addr), NREG - 1);
    for (int i = 1; i < NREG; i++) rd_reg(i, exp_rf[i], "R10 reg readback");
    drain();

    // R4: register 0 load ignored
    send(OP_LDR, 10'h000, 32'hFFFF_FFFF, RC_ACK, OP_LDR, '0, "R4 ack");
    drain();
    chk("R4 no rf_we", rf_cnt, NREG - 1);
    rd_reg(0, '0, "R4 r0 zero");
    drain();

    // R9/R10: stats untouched by idle events
    rd_stats("R9 idle");

    // R6/R8/R9/R7: run ended by halt, load held back meanwhile
    send(OP_RUN, '0, '0, RC_DONE_HALT, OP_RUN, '0, "R7 done halt");
    #1 chk("R6 dp_run high", XLEN'(dp_run), 1);
    fork
      send(OP_LDR, 10'h006, 32'h6666_0006, RC_ACK, OP_LDR, '0, "R6 held load ack");
      begin
        @(negedge clk); dp_retire = 1;
        @(negedge clk); dp_retire = 0; dp_mispredict = 1; wb_valid = 1; wb_addr = 5; wb_data = 32'hCAFE;
        @(negedge clk); dp_mispredict = 0; dp_retire = 1; wb_addr = 0; wb_data = 32'hBEEF;
        @(negedge clk); wb_valid = 0; dp_retire = 1;
        @(negedge clk); dp_retire = 0;
        #1 chk("R6 cmd_ready low in run", XLEN'(cmd_ready), 0);
        chk("R6 no rf_we in run", rf_cnt, NREG - 1);
        @(negedge clk); dp_halt = 1;
        @(negedge clk); dp_halt = 0;
        #1 chk("R7 dp_run low after halt", XLEN'(dp_run), 0);
      end
    join
    drain();
    exp_rf[5] = 32'hCAFE;
    exp_rf[6] = 32'h6666_0006;
    rd_reg(5, exp_rf[5], "R8 wb captured");
    rd_reg(0, '0, "R4 wb to r0 ignored");
    rd_reg(6, exp_rf[6], "R6 held load applied");
    drain();
    rd_stats("R9 run1");

    // R8: writeback while idle ignored
    @(negedge clk); wb_valid = 1; wb_addr = 2; wb_data = 32'hDEAD;
    @(negedge clk); wb_valid = 0;
    rd_reg(2, exp_rf[2], "R8 idle wb ignored");
    drain();

    // R7/R9/R1: long run ended by stop, counter wraps, backpressure
    send(OP_RUN, '0, '0, RC_DONE_STOP, OP_RUN, '0, "R7 done stop");
    @(negedge clk); dp_retire = 1;
    repeat (300) @(negedge clk);
    dp_retire = 0;
    rsp_ready = 0;
    send(OP_STOP, '0, '0, RC_ACK, OP_STOP, '0, "R7 stop ack");
    repeat (3) @(negedge clk);
    #1 chk("R1 held valid", XLEN'(rsp_valid), 1);
    chk("R1 held code", XLEN'(rsp_code), XLEN'(RC_DONE_STOP));
    chk("R7 dp_run low after stop", XLEN'(dp_run), 0);
    @(negedge clk); rsp_ready = 1;
    drain();
    chk("R9 wrap occurred", XLEN'(m_cyc >= CMOD), 1);
    rd_stats("R9 wrap");

    // R7: halt and stop in the same cycle, halt wins
    send(OP_RUN, '0, '0, RC_DONE_HALT, OP_RUN, '0, "R7 tie halt wins");
    repeat (2) @(negedge clk);
    fork
      send(OP_STOP, '0, '0, RC_ACK, OP_STOP, '0, "R7 tie stop ack");
      begin
        @(negedge clk); dp_halt = 1;
        @(negedge clk); dp_halt = 0;
      end
    join
    drain();

    // R7: stop while idle
    send(OP_STOP, '0, '0, RC_ACK, OP_STOP, '0, "R7 idle stop");
    drain();

    // R5: reset command clears counters and shadow registers
    send(OP_RST, '0, '0, RC_ACK, OP_RST, '0, "R5 ack");
    drain();
    chk("R5 reset pulse", rstp_cnt, 1);
    for (int i = 0; i < NREG; i++) exp_rf[i] = '0;
    rd_reg(5, '0, "R5 reg cleared");
    rd_reg(1, '0, "R5 reg1 cleared");
    drain();
    rd_stats("R5 counters cleared");

    // R11: unknown opcodes
    send(4'd7, 10'h001, 32'h1234, RC_BAD, 4'd7, '0, "R11 op7");
    send(4'd15, 10'h002, 32'h5678, RC_BAD, 4'd15, '0, "R11 op15");
    drain();
    chk("R11 no imem_we", imem_cnt, 2);
    chk("R11 no rf_we", rf_cnt, NREG);
    chk("R11 no reset", rstp_cnt, 1);
    chk("R11 not running", XLEN'(dp_run), 0);
    rd_reg(1, '0, "R11 reg untouched");
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule